// File: doc/BRIEF.md
# Flash Power Mode Controller

This block sets the power state of a parallel NOR-style flash memory interface. It watches the chip-enable, output-enable and power-down pins, the address bus, and a busy flag from the program/erase engine. From these it picks one of four states: active, automatic low-power read, standby, or deep power-down. It then drives the data-bus output enable, a low-power indication, an abort strobe to the program/erase engine, and a one-cycle clear pulse to the status register.

All three control pins and the address bus pass through two-flop synchronizers before use. A state change appears one clock after the synchronized edge. An idle-address detector moves a completed read into the automatic low-power state while the outputs stay driven. Deselecting during a program or erase waits for the operation to end before standby. Pulling the power-down pin low cuts the operation short with an abort strobe.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 11 (deep power-down) and `sr_clear_o` is high. After release with `rp_n_i` high and `ce_n_i` high, the block settles in standby (10) with `sr_clear_o` low.
- R2: With `ce_n_i` low and `rp_n_i` high, the block is in the active state, `state_o` = 00, and `low_pwr_o` is 0.
- R3: In the active state, with `oe_n_i` low, `pe_busy_i` low and the synchronized address unchanged for `IDLE_CYCLES` clocks, the block enters state 01. In that state `low_pwr_o` is 1 and `dq_oe_o` stays 1.
- R4: In state 01, a change of address (or a busy flag) returns the block to state 00. With a steady address and no busy flag, it stays in 01.
- R5: With `ce_n_i` high and no operation in progress, the block is in standby (10). In standby `dq_oe_o` is 0 for either level of `oe_n_i`.
- R6: If `ce_n_i` goes high while `pe_busy_i` is high, the block stays in 00. It enters 10 on the clock after `pe_busy_i` falls.
- R7: With `rp_n_i` low, the block is in state 11, `dq_oe_o` is 0 and `low_pwr_o` is 1.
- R8: When `rp_n_i` goes low while `pe_busy_i` is high, `pe_abort_o` is high for exactly one cycle, the first cycle in state 11. Entering 11 without busy gives no strobe.
- R9: Every entry into state 11 gives a one-cycle `sr_clear_o` pulse on the first cycle in that state.
- R10: In state 11, `ce_n_i` and `oe_n_i` are ignored. When `rp_n_i` returns high, the block goes to 10 if `ce_n_i` is high and to 00 if it is low.
- R11: `dq_oe_o` is 1 only in states 00 or 01 with `oe_n_i` low.
- R12: A pin change driven between two clock edges shows up on `state_o` after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ce_n_i | input | 1 | Chip enable pin, active low |
| oe_n_i | input | 1 | Output enable pin, active low |
| rp_n_i | input | 1 | Reset/power-down pin, active low |
| addr_i | input | ADDR_W | Address bus |
| pe_busy_i | input | 1 | Program/erase engine busy flag |
| dq_oe_o | output | 1 | Data bus output enable |
| low_pwr_o | output | 1 | High in any state other than active |
| pe_abort_o | output | 1 | One-cycle abort strobe to the program/erase engine |
| sr_clear_o | output | 1 | Status register clear pulse |
| state_o | output | 2 | Power state: 00 active, 01 auto low power, 10 standby, 11 deep power-down |

## Verification
Several rules are checked by the assertions on every cycle. A low synchronized power-down pin always leads to deep power-down. The busy flag keeps the active state from dropping to standby. Abort and clear pulses only occur on entry to deep power-down. The bus enable is never on in standby or deep power-down. The exit from deep power-down follows the chip-enable level.

Other behaviour can only be shown by the bench scenarios. These are the three-edge pin latency, the exact idle time before automatic low power, and the return to active across a sweep of addresses. They also include the sweep of chip-enable and output-enable levels that deep power-down ignores, and the settling after power-on reset.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'b00,
    PS_AUTO_LP = 2'b01,
    PS_STANDBY = 2'b10,
    PS_DEEP_PD = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fpc_idle_det.sv
module fpc_idle_det #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_s_i,
  output logic              quiet_o,
  output logic              changed_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IDLE_CYCLES);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              addr_en;

  always_comb begin
    changed_o = (addr_s_i != addr_q);
    addr_en   = changed_o;
    if (changed_o)          cnt_d = '0;
    else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_s_i;
      cnt_q <= cnt_d;
    end
  end

  assign quiet_o = (cnt_q == CNT_MAX) && !changed_o;
endmodule

// File: rtl/fpc_fsm.sv
module fpc_fsm
  import flash_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n_s_i,
  input  logic       oe_n_s_i,
  input  logic       rp_n_s_i,
  input  logic       busy_i,
  input  logic       quiet_i,
  input  logic       addr_chg_i,
  output pwr_state_e state_o,
  output logic       abort_o,
  output logic       clr_o
);
  pwr_state_e state_q, state_d;
  logic       abort_d, clr_d;
  logic       enter_dpd;

  always_comb begin
    state_d = state_q;
    if (!rp_n_s_i) begin
      state_d = PS_DEEP_PD;
    end else begin
      unique case (state_q)
        PS_ACTIVE: begin
          if (ce_n_s_i && !busy_i)
            state_d = PS_STANDBY;
          else if (!ce_n_s_i && !busy_i && !oe_n_s_i && quiet_i)
            state_d = PS_AUTO_LP;
        end
        PS_AUTO_LP: begin
          if (busy_i || addr_chg_i) state_d = PS_ACTIVE;
          else if (ce_n_s_i)        state_d = PS_STANDBY;
        end
        PS_STANDBY: begin
          if (!ce_n_s_i) state_d = PS_ACTIVE;
        end
        PS_DEEP_PD: begin
          state_d = ce_n_s_i ? PS_STANDBY : PS_ACTIVE;
        end
        default: state_d = PS_DEEP_PD;
      endcase
    end
    enter_dpd = (state_d == PS_DEEP_PD) && (state_q != PS_DEEP_PD);
    clr_d     = enter_dpd;
    abort_d   = enter_dpd && busy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_DEEP_PD;
      clr_o   <= 1'b1;
      abort_o <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_o   <= clr_d;
      abort_o <= abort_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import flash_pwr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              rp_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pe_busy_i,
  output logic              dq_oe_o,
  output logic              low_pwr_o,
  output logic              pe_abort_o,
  output logic              sr_clear_o,
  output logic [1:0]        state_o
);
  localparam int unsigned CTL_W = 3;

  logic             rst_meta_q, rst_s;
  logic [CTL_W-1:0] ctl_s;
  logic             ce_n_s, oe_n_s, rp_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic             quiet, addr_chg;
  pwr_state_e       state;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  // control pins: ce_n, oe_n idle high; rp_n held low (power-down) in reset
  fpc_sync #(.W(CTL_W), .RST_VAL(3'b011)) u_ctl_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d_i   ({rp_n_i, oe_n_i, ce_n_i}),
    .q_o   (ctl_s)
  );
  assign ce_n_s = ctl_s[0];
  assign oe_n_s = ctl_s[1];
  assign rp_n_s = ctl_s[2];

  fpc_sync #(.W(ADDR_W), .RST_VAL('0)) u_addr_sync (
    .clk   (clk),
    .rst_n (rst_s),
    .d_i   (addr_i),
    .q_o   (addr_s)
  );

  fpc_idle_det #(.ADDR_W(ADDR_W), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk       (clk),
    .rst_n     (rst_s),
    .addr_s_i  (addr_s),
    .quiet_o   (quiet),
    .changed_o (addr_chg)
  );

  fpc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_s),
    .ce_n_s_i   (ce_n_s),
    .oe_n_s_i   (oe_n_s),
    .rp_n_s_i   (rp_n_s),
    .busy_i     (pe_busy_i),
    .quiet_i    (quiet),
    .addr_chg_i (addr_chg),
    .state_o    (state),
    .abort_o    (pe_abort_o),
    .clr_o      (sr_clear_o)
  );

  assign state_o   = state;
  assign low_pwr_o = (state != PS_ACTIVE);
  assign dq_oe_o   = ((state == PS_ACTIVE) || (state == PS_AUTO_LP)) && !oe_n_s;
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic       clk,
  input logic       rst_s,
  input logic       ce_n_s,
  input logic       rp_n_s,
  input logic       busy,
  input logic       addr_chg,
  input logic [1:0] state,
  input logic       dq_oe,
  input logic       abort,
  input logic       clr
);
  AST_RP_LOW_DEEP_PD: assert property (@(posedge clk) disable iff (!rst_s)
    !rp_n_s |=> state == 2'b11); // R7

  AST_BUSY_BLOCKS_STBY: assert property (@(posedge clk) disable iff (!rst_s)
    (state == 2'b00 && busy) |=> state != 2'b10); // R6

  AST_ABORT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    abort |-> ($past(busy) && state == 2'b11 && $past(state) != 2'b11)); // R8

  AST_CLR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_s)
    (state == 2'b11 && $past(state) != 2'b11) |-> clr); // R9

  AST_DPD_EXIT_BY_CE: assert property (@(posedge clk) disable iff (!rst_s)
    (state == 2'b11 && rp_n_s) |=> state == ($past(ce_n_s) ? 2'b10 : 2'b00)); // R10

  AST_AUTO_LP_HOLDS: assert property (@(posedge clk) disable iff (!rst_s)
    (state == 2'b01 && rp_n_s && !ce_n_s && !busy && !addr_chg) |=> state == 2'b01); // R4

  AST_NO_DRIVE_LOW_STATES: assert property (@(posedge clk) disable iff (!rst_s)
    state[1] |-> !dq_oe); // R11
endmodule

bind flash_pwr_ctrl fpc_checker u_chk (
  .clk      (clk),
  .rst_s    (rst_s),
  .ce_n_s   (ce_n_s),
  .rp_n_s   (rp_n_s),
  .busy     (pe_busy_i),
  .addr_chg (addr_chg),
  .state    (state_o),
  .dq_oe    (dq_oe_o),
  .abort    (pe_abort_o),
  .clr      (sr_clear_o)
);

// File: tb/flash_pwr_ctrl_tb.sv
module flash_pwr_ctrl_tb;
  localparam int unsigned AW   = 4;
  localparam int unsigned IDLE = 4;

  logic clk, rst_n, ce_n, oe_n, rp_n, busy;
  logic [AW-1:0] addr;
  logic dq_oe, low_pwr, abort, clr;
  logic [1:0] st;
  int checks, fails;

  flash_pwr_ctrl #(.ADDR_W(AW), .IDLE_CYCLES(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .rp_n_i(rp_n),
    .addr_i(addr), .pe_busy_i(busy), .dq_oe_o(dq_oe), .low_pwr_o(low_pwr),
    .pe_abort_o(abort), .sr_clear_o(clr), .state_o(st)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; rp_n = 1'b1; busy = 1'b0; addr = '0;
    tick(3);
    chk("R1 state in reset", {2'b0, st}, 4'h3);
    chk("R1 clear in reset", {3'b0, clr}, 4'h1);
    rst_n = 1'b1;
    tick(10);
    chk("R1 settle standby", {2'b0, st}, 4'h2);
    chk("R1 clear dropped", {3'b0, clr}, 4'h0);

    // R12 latency, R2 active
    ce_n = 1'b0;
    tick(2);
    chk("R12 not after two edges", {2'b0, st}, 4'h2);
    tick(1);
    chk("R12 after three edges", {2'b0, st}, 4'h0);
    chk("R2 low_pwr", {3'b0, low_pwr}, 4'h0);

    // R3 auto low power
    oe_n = 1'b0;
    tick(IDLE + 6);
    chk("R3 auto low power", {2'b0, st}, 4'h1);
    chk("R3 outputs driven", {3'b0, dq_oe}, 4'h1);
    chk("R3 low_pwr", {3'b0, low_pwr}, 4'h1);

    // R4 sweep of new addresses
    for (int a = 1; a < (1 << AW); a++) begin
      addr = AW'(a);
      tick(3);
      chk("R4 new address wakes", {2'b0, st}, 4'h0);
      tick(2);
      chk("R4 still active", {2'b0, st}, 4'h0);
      tick(IDLE + 2);
      chk("R4 back to auto low power", {2'b0, st}, 4'h1);
    end
    busy = 1'b1;
    tick(1);
    chk("R4 busy wakes", {2'b0, st}, 4'h0);
    busy = 1'b0;

    // R5 standby, oe sweep
    for (int o = 0; o < 2; o++) begin
      oe_n = o[0];
      ce_n = 1'b1;
      tick(4);
      chk("R5 standby", {2'b0, st}, 4'h2);
      chk("R5 R11 no drive", {3'b0, dq_oe}, 4'h0);
      ce_n = 1'b0;
      tick(4);
      chk("R11 drive follows oe", {3'b0, dq_oe}, {3'b0, ~o[0]});
    end

    // R6 busy holds active
    busy = 1'b1;
    ce_n = 1'b1;
    tick(8);
    chk("R6 held active", {2'b0, st}, 4'h0);
    busy = 1'b0;
    tick(1);
    chk("R6 standby after busy", {2'b0, st}, 4'h2);

    // R7 R9 deep power-down from standby, no abort
    rp_n = 1'b0;
    tick(3);
    chk("R7 deep pd", {2'b0, st}, 4'h3);
    chk("R9 clear pulse", {3'b0, clr}, 4'h1);
    chk("R8 no abort when idle", {3'b0, abort}, 4'h0);
    chk("R7 no drive", {3'b0, dq_oe}, 4'h0);
    tick(1);
    chk("R9 clear one cycle", {3'b0, clr}, 4'h0);

    // R10 ce/oe ignored, exit by ce level
    for (int c = 0; c < 4; c++) begin
      ce_n = c[0]; oe_n = c[1];
      tick(4);
      chk("R10 ignored in deep pd", {2'b0, st}, 4'h3);
      chk("R10 low_pwr", {3'b0, low_pwr}, 4'h1);
      chk("R10 no clear", {3'b0, clr}, 4'h0);
    end
    ce_n = 1'b1;
    rp_n = 1'b1;
    tick(3);
    chk("R10 exit to standby", {2'b0, st}, 4'h2);
    rp_n = 1'b0;
    tick(4);
    ce_n = 1'b0;
    rp_n = 1'b1;
    tick(4);
    chk("R10 exit to active", {2'b0, st}, 4'h0);

    // R8 abort while busy
    busy = 1'b1;
    tick(1);
    rp_n = 1'b0;
    tick(3);
    chk("R8 abort strobe", {3'b0, abort}, 4'h1);
    chk("R9 clear with abort", {3'b0, clr}, 4'h1);
    tick(1);
    chk("R8 abort one cycle", {3'b0, abort}, 4'h0);
    busy = 1'b0;
    tick(2);
    finish_run();
  end
endmodule